// File: doc/BRIEF.md
# Status Packet Generator

This block reports a small status word, together with a rolling sequence number, as a short byte-serial packet on an 8-bit status bus. When a packet is due it takes a snapshot of the status, raises a request and presents its own fixed register address on the bus. The downstream side pulses an acknowledge when it takes that first byte. The remaining bytes then follow on consecutive clocks, and the bus returns to zero.

An 8-bit register write controls reporting. The two upper bits pick the mode: off, send one packet, or send automatically whenever the status changes. The six lower bits load the sequence number. The payload width is a parameter, and it sets how many bytes each packet carries.

Top module: `status_pkt_gen`

## Requirements
- R1: After reset the request output is 0, the byte output is 0, the mode is off and the sequence number is 0.
- R2: A write loads the sequence number from wr_data[5:0] and the mode from wr_data[7:6]: 2'b00 and 2'b10 are off, 2'b01 is send-once and 2'b11 is automatic.
- R3: After a send-once write, the request rises on the second rising clock edge after the write cycle. Exactly one packet is sent for that write.
- R4: A packet has 2 + ceil((PAYLOAD_BITS-2)/8) bytes, which is 4 bytes for the default 15-bit payload. While the request is high, the byte output holds STATUS_ADDR (default 8'h21).
- R5: Byte 1 is {seq[5:0], status[1:0]}. Byte k, for k of 2 or more, is status[2+8(k-2) +: 8]. Bits above the payload width are zero.
- R6: The request stays high, with the byte output unchanged, until pkt_start is seen high on a clock edge. A pkt_start pulse while the request is low has no effect.
- R7: The clock edge that samples pkt_start high with the request high drops the request and brings out byte 1. Each following edge brings out the next byte. One edge after the last byte, the byte output returns to 0.
- R8: The status carried in a packet is the value present on the clock edge that raised the request. Later changes to the status do not alter that packet.
- R9: Each packet carries the current sequence number, which then advances by one, wrapping from 63 to 0.
- R10: Writing automatic mode sends one packet straight away. After that, a packet is sent whenever the status differs from the value in the last packet, and no packet is sent while the status is unchanged.
- R11: In off mode no request is raised, whatever the status does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control value: [7:6] mode, [5:0] sequence number |
| status_in | input | PAYLOAD_BITS | Status word to report |
| pkt_start | input | 1 | Acknowledge that the first (address) byte was taken |
| pkt_req | output | 1 | Request to send a packet |
| pkt_byte | output | 8 | Packet byte stream, zero between packets |

## Verification
The bench builds the block with its defaults: a 15-bit payload and address 8'h21. This gives a 4-byte packet whose last byte carries only five status bits, so the zero padding of the top byte can be observed. With this size the sequence wrap from 63 to 0 is reached from a single write. The four-byte length also leaves several idle cycles between packets, where a held request, an ignored acknowledge and a suppressed change report can each be seen at the ports.

// File: rtl/sps_pkg.sv
package sps_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_ONCE = 2'b01,
      MODE_RSVD = 2'b10,
      MODE_AUTO = 2'b11
   } rep_mode_t;

   localparam int SEQ_W = 6;

   function automatic int pkt_bytes(input int payload_bits);
      return 2 + (payload_bits - 2 + 7) / 8;
   endfunction
endpackage

// File: rtl/sps_ctl.sv
module sps_ctl
   import sps_pkg::*;
#(
   parameter int PAYLOAD_BITS = 15
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [7:0]              wr_data,
   input  logic [PAYLOAD_BITS-1:0] status_in,
   input  logic                    busy,
   output logic                    launch,
   output logic [SEQ_W-1:0]        seq_now
);
   rep_mode_t               wr_mode;
   logic                    auto_en;
   logic                    pend;
   logic [SEQ_W-1:0]        seq_q;
   logic [PAYLOAD_BITS-1:0] last_q;
   logic                    changed;

   assign wr_mode = rep_mode_t'(wr_data[7:6]);
   assign changed = (status_in != last_q);
   assign launch  = !busy && !wr_en && (pend || (auto_en && changed));
   assign seq_now = seq_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         auto_en <= 1'b0;
         pend    <= 1'b0;
         seq_q   <= '0;
         last_q  <= '0;
      end else if (wr_en) begin
         seq_q   <= wr_data[SEQ_W-1:0];
         auto_en <= (wr_mode == MODE_AUTO);
         pend    <= (wr_mode == MODE_ONCE) || (wr_mode == MODE_AUTO);
      end else if (launch) begin
         pend    <= 1'b0;
         seq_q   <= seq_q + 1'b1;
         last_q  <= status_in;
      end
   end
endmodule

// File: rtl/sps_ser.sv
module sps_ser
   import sps_pkg::*;
#(
   parameter logic [7:0] STATUS_ADDR  = 8'h21,
   parameter int         PAYLOAD_BITS = 15
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    launch,
   input  logic [PAYLOAD_BITS-1:0] status_in,
   input  logic [SEQ_W-1:0]        seq_in,
   input  logic                    pkt_start,
   output logic                    pkt_req,
   output logic [7:0]              pkt_byte,
   output logic                    busy
);
   localparam int NB    = pkt_bytes(PAYLOAD_BITS);
   localparam int PADW  = 2 + 8 * (NB - 2);
   localparam int CNT_W = $clog2(NB) + 1;

   logic [PADW-1:0]   pad;
   logic [NB*8-1:0]   frame;
   logic [NB*8-1:0]   sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              active_q;
   logic              req_q;

   assign pad = PADW'(status_in);
   assign frame[7:0]  = STATUS_ADDR;
   assign frame[15:8] = {seq_in, pad[1:0]};

   for (genvar k = 2; k < NB; k++) begin : g_byte
      assign frame[8*k +: 8] = pad[2 + 8*(k-2) +: 8];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q     <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
         req_q    <= 1'b0;
      end else if (!active_q) begin
         if (launch) begin
            sr_q     <= frame;
            active_q <= 1'b1;
            req_q    <= 1'b1;
         end
      end else if (req_q) begin
         if (pkt_start) begin
            req_q <= 1'b0;
            sr_q  <= sr_q >> 8;
            cnt_q <= CNT_W'(NB - 2);
         end
      end else if (cnt_q == '0) begin
         active_q <= 1'b0;
      end else begin
         sr_q  <= sr_q >> 8;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pkt_req  = req_q;
   assign pkt_byte = active_q ? sr_q[7:0] : 8'h00;
   assign busy     = active_q;
endmodule

// File: rtl/status_pkt_gen.sv
module status_pkt_gen
   import sps_pkg::*;
#(
   parameter logic [7:0] STATUS_ADDR  = 8'h21,
   parameter int         PAYLOAD_BITS = 15
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [7:0]              wr_data,
   input  logic [PAYLOAD_BITS-1:0] status_in,
   input  logic                    pkt_start,
   output logic                    pkt_req,
   output logic [7:0]              pkt_byte
);
   if (PAYLOAD_BITS < 2 || PAYLOAD_BITS > 26) begin : g_bad_width
      $error("PAYLOAD_BITS must lie in 2..26");
   end

   logic             launch;
   logic             busy;
   logic [SEQ_W-1:0] seq_now;

   sps_ctl #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .status_in (status_in),
      .busy      (busy),
      .launch    (launch),
      .seq_now   (seq_now)
   );

   sps_ser #(.STATUS_ADDR(STATUS_ADDR), .PAYLOAD_BITS(PAYLOAD_BITS)) u_ser (
      .clk       (clk),
      .rst       (rst),
      .launch    (launch),
      .status_in (status_in),
      .seq_in    (seq_now),
      .pkt_start (pkt_start),
      .pkt_req   (pkt_req),
      .pkt_byte  (pkt_byte),
      .busy      (busy)
   );
endmodule

// File: rtl/status_pkt_gen_chk.sv
module status_pkt_gen_chk #(
   parameter logic [7:0] STATUS_ADDR = 8'h21,
   parameter int         NB          = 4
) (
   input logic       clk,
   input logic       rst,
   input logic       pkt_start,
   input logic       pkt_req,
   input logic [7:0] pkt_byte
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      pkt_req && !pkt_start |=> pkt_req && $stable(pkt_byte)); // R6

   AST_ADDR_ON_REQ: assert property (@(posedge clk) disable iff (rst)
      pkt_req |-> pkt_byte == STATUS_ADDR); // R4

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
      pkt_req && pkt_start |=> !pkt_req); // R7

   AST_NO_REQ_MIDPKT: assert property (@(posedge clk) disable iff (rst)
      (NB > 2) && $fell(pkt_req) |=> !pkt_req); // R7

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> !pkt_req && pkt_byte == 8'h00); // R1
endmodule

bind status_pkt_gen status_pkt_gen_chk #(
   .STATUS_ADDR (STATUS_ADDR),
   .NB          (sps_pkg::pkt_bytes(PAYLOAD_BITS))
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .pkt_start (pkt_start),
   .pkt_req   (pkt_req),
   .pkt_byte  (pkt_byte)
);

// File: tb/tb_status_pkt_gen.sv
`timescale 1ns/1ps
module tb_status_pkt_gen;
   localparam int PB = 15;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = 8'h00;
   logic [PB-1:0] status_in = '0;
   logic          pkt_start = 1'b0;
   logic          pkt_req;
   logic [7:0]    pkt_byte;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   status_pkt_gen dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .status_in(status_in), .pkt_start(pkt_start),
      .pkt_req(pkt_req), .pkt_byte(pkt_byte)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int k, input logic [5:0] sq, input logic [PB-1:0] st);
      logic [31:0] w;
      w = 32'(st);
      if (k == 0) return 8'h21;
      if (k == 1) return {sq, st[1:0]};
      return 8'((w >> (2 + 8*(k-2))) & 32'hFF);
   endfunction

   task automatic do_write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk({req, " no request"}, 32'(pkt_req), 0);
         chk({req, " bus zero"}, 32'(pkt_byte), 0);
      end
   endtask

   // Called right after do_write or a packet: request expected at next negedge.
   task automatic take_pkt(input string req, input logic [5:0] sq, input logic [PB-1:0] st);
      @(negedge clk);
      chk({req, " request raised"}, 32'(pkt_req), 1);
      chk({req, " R4 address byte"}, 32'(pkt_byte), 32'(exp_byte(0, sq, st)));
      pkt_start = 1'b1;
      @(negedge clk);
      pkt_start = 1'b0;
      chk({req, " R7 request dropped"}, 32'(pkt_req), 0);
      for (int k = 1; k < NB; k++) begin
         if (k > 1) @(negedge clk);
         chk({req, " R5 payload byte"}, 32'(pkt_byte), 32'(exp_byte(k, sq, st)));
      end
      @(negedge clk);
      chk({req, " R7 bus back to zero"}, 32'(pkt_byte), 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 reset request", 32'(pkt_req), 0);
      chk("R1 reset byte", 32'(pkt_byte), 0);
   endtask

   task automatic t_once;
      status_in = 15'h5A3D;
      do_write({2'b01, 6'd5});
      take_pkt("R3", 6'd5, 15'h5A3D);
      idle(4, "R3 single packet");
      do_write({2'b01, 6'd20});
      take_pkt("R2 R9 step a", 6'd20, 15'h5A3D);
      do_write({2'b01, 6'd20});
      take_pkt("R2 R9 reload", 6'd20, 15'h5A3D);
   endtask

   task automatic t_hold;
      status_in = 15'h7FFF;
      do_write({2'b01, 6'd9});
      @(negedge clk);
      chk("R6 request up", 32'(pkt_req), 1);
      status_in = 15'h0001;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R6 request held", 32'(pkt_req), 1);
         chk("R6 address held", 32'(pkt_byte), 8'h21);
      end
      pkt_start = 1'b1;
      @(negedge clk);
      pkt_start = 1'b0;
      chk("R8 snapshot byte1", 32'(pkt_byte), 32'(exp_byte(1, 6'd9, 15'h7FFF)));
      @(negedge clk);
      chk("R8 snapshot byte2", 32'(pkt_byte), 32'(exp_byte(2, 6'd9, 15'h7FFF)));
      @(negedge clk);
      chk("R8 R5 padded byte3", 32'(pkt_byte), 8'h1F);
      @(negedge clk);
      chk("R7 zero after", 32'(pkt_byte), 0);
   endtask

   task automatic t_stray_start;
      pkt_start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      pkt_start = 1'b0;
      chk("R6 stray start req", 32'(pkt_req), 0);
      chk("R6 stray start byte", 32'(pkt_byte), 0);
      status_in = 15'h1234;
      do_write({2'b01, 6'd3});
      take_pkt("R6 after stray start", 6'd3, 15'h1234);
   endtask

   task automatic t_wrap;
      status_in = 15'h0ABC;
      do_write({2'b01, 6'd63});
      take_pkt("R9 seq 63", 6'd63, 15'h0ABC);
      do_write({2'b11, 6'd63});
      take_pkt("R10 baseline", 6'd63, 15'h0ABC);
      status_in = 15'h0ABD;
      take_pkt("R9 wrap to 0", 6'd0, 15'h0ABD);
   endtask

   task automatic t_auto;
      idle(5, "R10 unchanged");
      status_in = 15'h6003;
      take_pkt("R10 change 1", 6'd1, 15'h6003);
      status_in = 15'h0400;
      take_pkt("R10 change 2", 6'd2, 15'h0400);
      idle(4, "R10 steady");
   endtask

   task automatic t_off;
      do_write({2'b00, 6'd0});
      status_in = 15'h1111;
      idle(3, "R11 off a");
      status_in = 15'h2222;
      idle(3, "R11 off b");
      do_write({2'b10, 6'd0});
      status_in = 15'h3333;
      idle(4, "R2 R11 mode 10");
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst = 1'b0;
            t_reset();
            t_once();
            t_hold();
            t_stray_start();
            t_wrap();
            t_auto();
            t_off();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule